// File: doc/BRIEF.md
# Guest-Entry Failure Reporter

This block decides what is written back when an attempt to enter a guest fails late: after the guest-state checks have started, while the model-specific-register load list is being processed, or when a machine check arrives during the attempt. It holds the first failure cause of the current attempt. On a one-cycle commit strobe it writes a 32-bit exit-reason register and an exit-qualification register. In the same update it restores the NMI-blocking bit to the value it had when the attempt began. It raises a host-reload start pulse together with the register update and a done pulse one cycle later.

Machine checks take one of three paths, chosen by how far the entry has progressed. If no guest state has been loaded, the event is handled as an ordinary exception, or as a shutdown when the machine-check enable is off. Once guest state has been loaded, the event becomes an entry failure. Host-state reload and the register-load datapath are not part of this block. They see only the handshake pulses.

Top module: `vmentry_fail_reporter`

## Requirements
- R1: The low 16 bits of the exit reason are 33 (decimal) for a guest-state failure, 34 for a register-load failure and 41 for a machine-check failure.
- R2: Every committed exit reason has bit 31 set and bits 30:16 zero. After reset both registers read 0.
- R3: The guest-state sub-cause vector maps bit 0 to qualification 2, bit 1 to 3 and bit 2 to 4. With several bits set the lowest code wins. With none set the qualification is 0, and it is never 1.
- R4: For a register-load failure the qualification is the 0-based failing index plus 1.
- R5: The exit-reason, qualification and NMI-blocking outputs change only on a commit that finds a captured failure. A commit with nothing captured changes nothing and gives no done pulse.
- R6: A commit sets the NMI-blocking output to the NMI-blocking input value sampled at the last entry_start.
- R7: A machine check while guest_loaded is 0 sets the path output, one cycle later, to 1 (exception) if the enable is 1 and to 2 (shutdown) if it is 0. It records no failure.
- R8: A machine check while guest_loaded is 1 sets the path to 3 (entry failure) and records reason 41 with qualification 0.
- R9: The first captured cause of an attempt is kept. Causes that arrive in the same cycle rank machine check (guest loaded) first, then register load, then guest state.
- R10: Registers are visible the cycle after commit, host_reload_go is high in that same cycle only, and done is high in the following cycle only.
- R11: entry_start clears the captured failure and sets the path to 0 (none), unless a strobe arrives in the same cycle. A commit also clears the captured failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| entry_start | input | 1 | Start of an entry attempt; samples NMI blocking |
| nmi_block_in | input | 1 | Current NMI-blocking value |
| guest_loaded | input | 1 | Some guest state is already loaded |
| mce_enable | input | 1 | Machine-check enable control |
| gs_fail | input | 1 | Guest-state failure strobe |
| gs_subcause | input | NSUB | Guest-state sub-cause bits |
| msr_fail | input | 1 | Register-load failure strobe |
| msr_index | input | IDX_W | 0-based failing load-list index |
| mc_event | input | 1 | Machine-check strobe |
| commit | input | 1 | Write-back strobe |
| exit_reason | output | 32 | Exit-reason register |
| exit_qual | output | QW | Exit-qualification register |
| nmi_block_out | output | 1 | Restored NMI-blocking bit |
| mc_path | output | 2 | 0 none, 1 exception, 2 shutdown, 3 entry failure |
| host_reload_go | output | 1 | Host reload start pulse |
| done | output | 1 | Completion pulse |

## Verification
A strobe becomes a captured cause at the next edge. The machine-check path appears one cycle after its strobe. Reason, qualification, NMI bit and host_reload_go appear one cycle after commit, and done appears two cycles after it. The bench drives inputs on falling edges and lets a behavioural model advance on each rising edge. It then compares every output on the next falling edge, so each result is checked in exactly the cycle it is due. Directed checks after each commit also pin the literal codes.

// File: rtl/vefr_pkg.sv
package vefr_pkg;
  typedef enum logic [1:0] {
    MCP_NONE      = 2'd0,
    MCP_EXCEPTION = 2'd1,
    MCP_SHUTDOWN  = 2'd2,
    MCP_ENTRYFAIL = 2'd3
  } mc_path_e;

  localparam logic [15:0] RSN_GUEST = 16'd33;
  localparam logic [15:0] RSN_MSR   = 16'd34;
  localparam logic [15:0] RSN_MC    = 16'd41;
  localparam int          GS_BASE   = 2;
endpackage

// File: rtl/vefr_qual_enc.sv
module vefr_qual_enc #(
  parameter int NSUB = 3,
  parameter int QW   = 32
) (
  input  logic [NSUB-1:0] sub,
  output logic [QW-1:0]   qual
);
  import vefr_pkg::*;
  always_comb begin
    qual = '0;
    for (int i = NSUB - 1; i >= 0; i--) begin
      if (sub[i]) qual = QW'(i + GS_BASE);
    end
  end
endmodule

// File: rtl/vefr_mc_route.sv
module vefr_mc_route (
  input  logic              guest_loaded,
  input  logic              mce_enable,
  output vefr_pkg::mc_path_e path
);
  import vefr_pkg::*;
  always_comb begin
    if (guest_loaded)    path = MCP_ENTRYFAIL;
    else if (mce_enable) path = MCP_EXCEPTION;
    else                 path = MCP_SHUTDOWN;
  end
endmodule

// File: rtl/vefr_capture.sv
module vefr_capture #(
  parameter int QW    = 32,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_start,
  input  logic             commit,
  input  logic             mc_fail,
  input  logic             msr_fail,
  input  logic [IDX_W-1:0] msr_index,
  input  logic             gs_fail,
  input  logic [QW-1:0]    gs_qual,
  output logic             pend_valid,
  output logic [15:0]      pend_code,
  output logic [QW-1:0]    pend_qual
);
  import vefr_pkg::*;
  logic            any;
  logic [15:0]     c_code;
  logic [QW-1:0]   c_qual;

  always_comb begin
    any    = mc_fail | msr_fail | gs_fail;
    c_code = RSN_GUEST;
    c_qual = gs_qual;
    if (mc_fail) begin
      c_code = RSN_MC;
      c_qual = '0;
    end else if (msr_fail) begin
      c_code = RSN_MSR;
      c_qual = QW'(msr_index) + QW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      pend_code  <= '0;
      pend_qual  <= '0;
    end else if (commit) begin
      pend_valid <= 1'b0;
    end else if (clear_start || (!pend_valid && any)) begin
      pend_valid <= any;
      pend_code  <= c_code;
      pend_qual  <= c_qual;
    end
  end
endmodule

// File: rtl/vmentry_fail_reporter.sv
module vmentry_fail_reporter #(
  parameter int NSUB  = 3,
  parameter int QW    = 32,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             entry_start,
  input  logic             nmi_block_in,
  input  logic             guest_loaded,
  input  logic             mce_enable,
  input  logic             gs_fail,
  input  logic [NSUB-1:0]  gs_subcause,
  input  logic             msr_fail,
  input  logic [IDX_W-1:0] msr_index,
  input  logic             mc_event,
  input  logic             commit,
  output logic [31:0]      exit_reason,
  output logic [QW-1:0]    exit_qual,
  output logic             nmi_block_out,
  output logic [1:0]       mc_path,
  output logic             host_reload_go,
  output logic             done
);
  import vefr_pkg::*;
  localparam int RSV_W = 32 - 16 - 1;

  logic [QW-1:0] gs_qual;
  mc_path_e      route;
  logic          pend_valid;
  logic [15:0]   pend_code;
  logic [QW-1:0] pend_qual;
  logic          nmi_snap;
  logic          wr;

  vefr_qual_enc #(.NSUB(NSUB), .QW(QW)) u_enc (
    .sub(gs_subcause), .qual(gs_qual)
  );

  vefr_mc_route u_route (
    .guest_loaded(guest_loaded), .mce_enable(mce_enable), .path(route)
  );

  vefr_capture #(.QW(QW), .IDX_W(IDX_W)) u_cap (
    .clk(clk), .rst(rst), .clear_start(entry_start), .commit(commit),
    .mc_fail(mc_event & guest_loaded), .msr_fail(msr_fail),
    .msr_index(msr_index), .gs_fail(gs_fail), .gs_qual(gs_qual),
    .pend_valid(pend_valid), .pend_code(pend_code), .pend_qual(pend_qual)
  );

  assign wr = commit & pend_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      exit_reason    <= '0;
      exit_qual      <= '0;
      nmi_block_out  <= 1'b0;
      nmi_snap       <= 1'b0;
      mc_path        <= MCP_NONE;
      host_reload_go <= 1'b0;
      done           <= 1'b0;
    end else begin
      host_reload_go <= wr;
      done           <= host_reload_go;
      if (entry_start) nmi_snap <= nmi_block_in;
      if (mc_event)         mc_path <= route;
      else if (entry_start) mc_path <= MCP_NONE;
      if (wr) begin
        exit_reason   <= {1'b1, {RSV_W{1'b0}}, pend_code};
        exit_qual     <= pend_qual;
        nmi_block_out <= nmi_snap;
      end
    end
  end
endmodule

// File: rtl/vefr_checker.sv
module vefr_checker #(
  parameter int QW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [31:0]   exit_reason,
  input logic [QW-1:0] exit_qual,
  input logic          nmi_block_out,
  input logic          host_reload_go,
  input logic          done
);
  assert_reason_format_R2: assert property (@(posedge clk) disable iff (rst)
    host_reload_go |-> (exit_reason[31] && exit_reason[30:16] == '0));
  assert_reason_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !host_reload_go |-> $stable(exit_reason) && $stable(exit_qual));
  assert_nmi_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !host_reload_go |-> $stable(nmi_block_out));
  assert_done_follows_R10: assert property (@(posedge clk) disable iff (rst)
    host_reload_go |=> done);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_gs_qual_not1_R3: assert property (@(posedge clk) disable iff (rst)
    (host_reload_go && exit_reason[15:0] == 16'd33) |-> exit_qual != QW'(1));
  assert_mc_qual_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (host_reload_go && exit_reason[15:0] == 16'd41) |-> exit_qual == '0);
endmodule

bind vmentry_fail_reporter vefr_checker #(.QW(QW)) u_vefr_chk (
  .clk(clk), .rst(rst), .exit_reason(exit_reason), .exit_qual(exit_qual),
  .nmi_block_out(nmi_block_out), .host_reload_go(host_reload_go), .done(done)
);

// File: tb/test_vmentry_fail_reporter.sv
`timescale 1ns/1ps
module test_vmentry_fail_reporter;
  localparam int NSUB = 3, QW = 32, IDX_W = 8;
  logic clk = 0, rst = 1;
  logic entry_start = 0, nmi_block_in = 0, guest_loaded = 0, mce_enable = 0;
  logic gs_fail = 0, msr_fail = 0, mc_event = 0, commit = 0;
  logic [NSUB-1:0] gs_subcause = '0;
  logic [IDX_W-1:0] msr_index = '0;
  logic [31:0] exit_reason;
  logic [QW-1:0] exit_qual;
  logic nmi_block_out, host_reload_go, done;
  logic [1:0] mc_path;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  vmentry_fail_reporter #(.NSUB(NSUB), .QW(QW), .IDX_W(IDX_W)) i_vmentry_fail_reporter (.*);

  // behavioural reference model
  logic [31:0] e_reason, e_qual, p_qual, c_qual;
  logic [15:0] p_code, c_code;
  logic e_nmi, e_reload, e_done, p_valid, snap, c_any;
  int e_path;
  always @(posedge clk) begin
    if (rst) begin
      e_reason = 0; e_qual = 0; e_nmi = 0; e_reload = 0; e_done = 0;
      p_valid = 0; p_code = 0; p_qual = 0; snap = 0; e_path = 0;
    end else begin
      e_done = e_reload;
      e_reload = commit && p_valid;
      if (e_reload) begin
        e_reason = 32'h8000_0000 | 32'(p_code); e_qual = p_qual; e_nmi = snap;
      end
      c_any = 1; c_qual = 0;
      if (mc_event && guest_loaded) c_code = 41;
      else if (msr_fail) begin c_code = 34; c_qual = 32'(msr_index) + 1; end
      else if (gs_fail) begin
        c_code = 33;
        if (gs_subcause[0]) c_qual = 2;
        else if (gs_subcause[1]) c_qual = 3;
        else if (gs_subcause[2]) c_qual = 4;
      end else begin c_any = 0; c_code = 0; end
      if (commit) p_valid = 0;
      else if (entry_start || (!p_valid && c_any)) begin
        p_valid = c_any; p_code = c_code; p_qual = c_qual;
      end
      if (entry_start) snap = nmi_block_in;
      if (mc_event) e_path = guest_loaded ? 3 : (mce_enable ? 1 : 2);
      else if (entry_start) e_path = 0;
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    chk("R1 reason", exit_reason, e_reason);
    chk("R3 qual", exit_qual, e_qual);
    chk("R6 nmi", nmi_block_out, e_nmi);
    chk("R7 path", mc_path, e_path);
    chk("R10 reload", host_reload_go, e_reload);
    chk("R10 done", done, e_done);
  endtask

  task automatic clr();
    entry_start = 0; gs_fail = 0; msr_fail = 0; mc_event = 0; commit = 0;
  endtask

  // one commit; returns after the register update is visible
  task automatic do_commit();
    commit = 1; tick(); clr();
  endtask

  task automatic start(logic nmi);
    entry_start = 1; nmi_block_in = nmi; tick(); clr();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset reason", exit_reason, 0);
    chk("R2 reset qual", exit_qual, 0);
    chk("R10 reset done", done, 0);
    chk("R11 reset path", mc_path, 0);
    rst = 0; tick();

    // R1/R3 guest state, no sub-cause
    start(0); gs_fail = 1; gs_subcause = 3'b000; tick(); clr();
    do_commit();
    chk("R1 gs reason", exit_reason, 32'h8000_0021);
    chk("R3 gs qual none", exit_qual, 0);
    chk("R10 reload pulse", host_reload_go, 1);
    tick(); chk("R10 done pulse", done, 1);
    tick(); chk("R10 done single", done, 0);

    // R3 sub-cause priorities
    start(0); gs_fail = 1; gs_subcause = 3'b110; tick(); clr(); do_commit();
    chk("R3 qual lowest 3", exit_qual, 3);
    start(0); gs_fail = 1; gs_subcause = 3'b101; tick(); clr(); do_commit();
    chk("R3 qual lowest 2", exit_qual, 2);
    start(0); gs_fail = 1; gs_subcause = 3'b100; tick(); clr(); do_commit();
    chk("R3 qual 4", exit_qual, 4);

    // R4 register-load index
    foreach (msr_index[i]) begin end
    for (int k = 0; k < 3; k++) begin
      int idx = (k == 0) ? 0 : (k == 1) ? 6 : 255;
      start(0); msr_fail = 1; msr_index = IDX_W'(idx); tick(); clr(); do_commit();
      chk("R1 msr reason", exit_reason, 32'h8000_0022);
      chk("R4 msr qual", exit_qual, idx + 1);
    end

    // R5 commit with nothing captured
    start(1); tick(); do_commit();
    chk("R5 no update reason", exit_reason, 32'h8000_0022);
    chk("R5 no reload", host_reload_go, 0);
    tick(); chk("R5 no done", done, 0);

    // R6 NMI restore uses value at entry start
    start(1); nmi_block_in = 0; gs_fail = 1; gs_subcause = 0; tick(); clr();
    do_commit(); chk("R6 nmi restored", nmi_block_out, 1);
    start(0); nmi_block_in = 1; msr_fail = 1; tick(); clr();
    do_commit(); chk("R6 nmi restored 0", nmi_block_out, 0);

    // R7 normal machine-check handling
    start(0); guest_loaded = 0; mce_enable = 1; mc_event = 1; tick(); clr();
    chk("R7 exception path", mc_path, 1);
    mce_enable = 0; mc_event = 1; tick(); clr();
    chk("R7 shutdown path", mc_path, 2);
    do_commit(); chk("R7 no failure recorded", host_reload_go, 0);

    // R8 machine check after guest load
    start(0); guest_loaded = 1; mc_event = 1; tick(); clr();
    chk("R8 entryfail path", mc_path, 3);
    do_commit();
    chk("R8 mc reason", exit_reason, 32'h8000_0029);
    chk("R8 mc qual", exit_qual, 0);

    // R9 first cause wins, then same-cycle ranking
    start(0); gs_fail = 1; gs_subcause = 3'b010; tick(); clr();
    msr_fail = 1; msr_index = 4; tick(); clr(); do_commit();
    chk("R9 first wins", exit_reason[15:0], 33);
    start(0); gs_fail = 1; msr_fail = 1; msr_index = 9; tick(); clr(); do_commit();
    chk("R9 msr over gs", exit_reason[15:0], 34);
    start(0); mc_event = 1; msr_fail = 1; tick(); clr(); do_commit();
    chk("R9 mc over msr", exit_reason[15:0], 41);
    guest_loaded = 0;

    // R11 entry start clears
    start(0); gs_fail = 1; tick(); clr(); start(0);
    chk("R11 path cleared", mc_path, 0);
    do_commit(); chk("R11 pending cleared", host_reload_go, 0);
    repeat (4) tick();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule